// File: doc/BRIEF.md
# Compare-and-Branch Control Sequencer

This block is a small multi-cycle controller around a shared-bus datapath. It holds a program counter, two instruction registers, an eight-entry register file, an ALU that can subtract, add, do bitwise logic or pass an operand through unchanged, and a four-bit condition-code register. A compare instruction subtracts one register from another and keeps only the resulting flags. A later two-word conditional branch reads those flags. The first branch word names the condition and the second word carries the target address. When the condition holds, the target is placed on the shared bus, passed through the ALU and loaded into the program counter.

Instruction words arrive over a fetch port with a valid/ready handshake. The controller raises `fetch_req` and presents `fetch_addr`. The word on `fetch_data` is taken in the cycle where `fetch_ack` is also high. The memory applies back-pressure by holding `fetch_ack` low; the controller then holds its request and address unchanged. A HALT instruction parks the controller until reset. A combinational observation port reads any register for inspection.

Instruction word (16 bits): opcode in bits 15:12, destination `rd` in 11:9, first source `ra` in 8:6, second source `rb` in 5:3, branch condition in 2:0, immediate byte in 7:0.

Top module: `cmpbr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0, `flags` becomes 0 and the controller returns to fetching; after reset `halted` is low and `fetch_req` is high.
- R2: A word is accepted on a rising edge where `fetch_req` and `fetch_ack` are both high, and `pc` then advances by one. While `fetch_ack` is low, `fetch_req` stays high and `fetch_addr` stays unchanged.
- R3: The opcodes are 0 NOP, 1 CMP, 2 BR, 3 LDI, 4 LHI, 5 ADD, 6 SUB, 7 AND, 8 OR and 15 HALT. Every other code behaves as NOP.
- R4: CMP computes `ra` minus `rb` and writes only the flags: `flags[3]` = zero, `flags[2]` = sign bit of the difference, `flags[1]` = signed overflow, `flags[0]` = carry out of `ra + ~rb + 1`. No register is written, including the one named in the `rd` field.
- R5: The flags change only when a CMP executes. NOP, HALT, branches and all register-writing instructions leave them unchanged.
- R6: BR takes two consecutive words: the first holds the condition and the second holds the target. If the condition holds, `pc` becomes the target; otherwise `pc` ends two past the first branch word.
- R7: The branch condition codes (Z, N, V from the flags) are: 0 always, 1 Z, 2 not Z, 3 N xor V, 4 Z or (N xor V), 5 neither Z nor (N xor V), 6 not (N xor V), 7 never.
- R8: ADD, SUB, AND and OR write `rd` with `ra` op `rb`. LDI writes `rd` with the zero-extended immediate byte. LHI replaces the upper byte of `rd` with the immediate byte and keeps its lower byte.
- R9: Once a HALT word is accepted, `halted` stays high, `fetch_req` stays low and `pc` stays unchanged until reset.
- R10: With `fetch_ack` held high, a single-word instruction takes 2 cycles, a branch takes 3, and `halted` rises on the edge that accepts the HALT word.
- R11: `obs_data` shows the current contents of the register selected by `obs_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Fetch request (valid) |
| fetch_addr | output | 8 | Address of the requested word |
| fetch_ack | input | 1 | Memory accepts and answers the request (ready) |
| fetch_data | input | 16 | Instruction word at `fetch_addr`, valid while acked |
| pc | output | 8 | Program counter |
| flags | output | 4 | Condition codes {Z, N, V, C} |
| halted | output | 1 | Controller parked after HALT |
| obs_sel | input | 3 | Register index to observe |
| obs_data | output | 16 | Contents of the observed register |

## Verification
The assertions assume `fetch_data` holds the word at `fetch_addr` in any cycle where `fetch_ack` is high, and that `rst` is held for at least one edge before checking begins. They place no demand on `fetch_ack` itself: stall, hold and sticky-halt properties must hold for any ack pattern. The stimulus serves the fetch port from a bench memory indexed by the live address and draws `fetch_ack` at random with a fixed seed. It applies reset between programs, so these premises are always met.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

  localparam logic [3:0] OPC_NOP  = 4'd0;
  localparam logic [3:0] OPC_CMP  = 4'd1;
  localparam logic [3:0] OPC_BR   = 4'd2;
  localparam logic [3:0] OPC_LDI  = 4'd3;
  localparam logic [3:0] OPC_LHI  = 4'd4;
  localparam logic [3:0] OPC_ADD  = 4'd5;
  localparam logic [3:0] OPC_SUB  = 4'd6;
  localparam logic [3:0] OPC_AND  = 4'd7;
  localparam logic [3:0] OPC_OR   = 4'd8;
  localparam logic [3:0] OPC_HALT = 4'd15;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_FETCH0, ST_FETCH1, ST_EXEC, ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    BUS_REG, BUS_TGT, BUS_IMM_LO, BUS_IMM_HI
  } bus_src_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/cmpbr_regfile.sv
module cmpbr_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [RW-1:0] raddr_a,
  input  logic [RW-1:0] raddr_b,
  input  logic [RW-1:0] raddr_o,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (waddr == RW'(i))) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_o = regs[raddr_o];

endmodule

// File: rtl/cmpbr_alu.sv
module cmpbr_alu
  import cmpbr_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output cc_t          cc
);

  logic [W:0]   sub_full;
  logic [W-1:0] diff;

  assign sub_full = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
  assign diff     = sub_full[W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = a;
    endcase
  end

  // flags always describe a - b; the sequencer latches them only for compares
  assign cc.z = (diff == '0);
  assign cc.n = diff[W-1];
  assign cc.v = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
  assign cc.c = sub_full[W];

endmodule

// File: rtl/cmpbr_cond.sv
module cmpbr_cond
  import cmpbr_pkg::*;
(
  input  logic [2:0] code,
  input  cc_t        cc,
  output logic       taken
);

  logic lt;
  assign lt = cc.n ^ cc.v;

  always_comb begin
    unique case (code)
      3'd0:    taken = 1'b1;
      3'd1:    taken = cc.z;
      3'd2:    taken = !cc.z;
      3'd3:    taken = lt;
      3'd4:    taken = cc.z | lt;
      3'd5:    taken = !(cc.z | lt);
      3'd6:    taken = !lt;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmpbr_seq.sv
module cmpbr_seq
  import cmpbr_pkg::*;
#(
  parameter int AW   = 8,
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG),
  localparam int HB  = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [W-1:0]  fetch_data,
  output logic [AW-1:0] pc,
  output logic [3:0]    flags,
  output logic          halted,
  input  logic [RW-1:0] obs_sel,
  output logic [W-1:0]  obs_data
);

  seq_state_e    state;
  logic [W-1:0]  i0, i1;
  cc_t           cc_q, alu_cc;

  logic [3:0]    op, fetch_op;
  logic [RW-1:0] f_rd, f_ra, f_rb, rsel_a;
  logic [2:0]    f_cond;
  logic [HB-1:0] f_imm;

  alu_op_e       alu_op;
  bus_src_e      bus_src;
  logic          writes_rd;
  logic [W-1:0]  rd_a, rd_b, bus, alu_y;
  logic          cond_ok;

  logic          exec_cmp, exec_br, br_taken, accept;

  assign op       = i0[W-1 -: 4];
  assign f_rd     = i0[W-5 -: RW];
  assign f_ra     = i0[W-5-RW -: RW];
  assign f_rb     = i0[W-5-2*RW -: RW];
  assign f_cond   = i0[2:0];
  assign f_imm    = i0[HB-1:0];
  assign fetch_op = fetch_data[W-1 -: 4];

  // decode of the held instruction word
  always_comb begin
    alu_op    = ALU_PASS;
    bus_src   = BUS_REG;
    writes_rd = 1'b0;
    rsel_a    = f_ra;
    unique case (op)
      OPC_CMP: alu_op = ALU_SUB;
      OPC_BR:  bus_src = BUS_TGT;
      OPC_LDI: begin bus_src = BUS_IMM_LO; writes_rd = 1'b1; end
      OPC_LHI: begin bus_src = BUS_IMM_HI; writes_rd = 1'b1; rsel_a = f_rd; end
      OPC_ADD: begin alu_op = ALU_ADD; writes_rd = 1'b1; end
      OPC_SUB: begin alu_op = ALU_SUB; writes_rd = 1'b1; end
      OPC_AND: begin alu_op = ALU_AND; writes_rd = 1'b1; end
      OPC_OR:  begin alu_op = ALU_OR;  writes_rd = 1'b1; end
      default: ;
    endcase
  end

  cmpbr_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      ((state == ST_EXEC) && writes_rd),
    .waddr   (f_rd),
    .wdata   (alu_y),
    .raddr_a (rsel_a),
    .raddr_b (f_rb),
    .raddr_o (obs_sel),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .rdata_o (obs_data)
  );

  // shared bus source select
  always_comb begin
    unique case (bus_src)
      BUS_TGT:    bus = i1;
      BUS_IMM_LO: bus = {{(W-HB){1'b0}}, f_imm};
      BUS_IMM_HI: bus = {f_imm, rd_a[HB-1:0]};
      default:    bus = rd_a;
    endcase
  end

  cmpbr_alu #(.W(W)) u_alu (
    .op (alu_op),
    .a  (bus),
    .b  (rd_b),
    .y  (alu_y),
    .cc (alu_cc)
  );

  cmpbr_cond u_cond (
    .code  (f_cond),
    .cc    (cc_q),
    .taken (cond_ok)
  );

  assign exec_cmp = (state == ST_EXEC) && (op == OPC_CMP);
  assign exec_br  = (state == ST_EXEC) && (op == OPC_BR);
  assign br_taken = exec_br && cond_ok;
  assign accept   = fetch_req && fetch_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH0;
      pc    <= '0;
      cc_q  <= '0;
      i0    <= '0;
      i1    <= '0;
    end else begin
      unique case (state)
        ST_FETCH0: if (accept) begin
          i0 <= fetch_data;
          pc <= pc + AW'(1);
          if (fetch_op == OPC_BR)        state <= ST_FETCH1;
          else if (fetch_op == OPC_HALT) state <= ST_HALT;
          else                           state <= ST_EXEC;
        end
        ST_FETCH1: if (accept) begin
          i1    <= fetch_data;
          pc    <= pc + AW'(1);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (exec_cmp) cc_q <= alu_cc;
          if (br_taken) pc <= alu_y[AW-1:0];
          state <= ST_FETCH0;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign fetch_req  = (state == ST_FETCH0) || (state == ST_FETCH1);
  assign fetch_addr = pc;
  assign flags      = cc_q;
  assign halted     = (state == ST_HALT);

endmodule

// File: rtl/cmpbr_seq_chk.sv
module cmpbr_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req,
  input logic          fetch_ack,
  input logic [AW-1:0] fetch_addr,
  input logic [AW-1:0] pc,
  input logic [3:0]    flags,
  input logic          halted,
  input logic          exec_cmp,
  input logic          exec_br,
  input logic          br_taken
);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_ack |=> pc == $past(pc) + AW'(1));

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !exec_cmp |=> $stable(flags));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    exec_br && !br_taken |=> $stable(pc));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc));

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !fetch_req);

endmodule

bind cmpbr_seq cmpbr_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_req  (fetch_req),
  .fetch_ack  (fetch_ack),
  .fetch_addr (fetch_addr),
  .pc         (pc),
  .flags      (flags),
  .halted     (halted),
  .exec_cmp   (exec_cmp),
  .exec_br    (exec_br),
  .br_taken   (br_taken)
);

// File: tb/cmpbr_seq_test.sv
`timescale 1ns/1ps
module cmpbr_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req, fetch_ack, halted;
  logic [7:0]  fetch_addr, pc;
  logic [15:0] fetch_data, obs_data;
  logic [3:0]  flags;
  logic [2:0]  obs_sel = '0;
  logic [15:0] imem [256];
  int          checks = 0, failures = 0;
  int          ack_pct = 100;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign fetch_data = imem[fetch_addr];

  cmpbr_seq uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .pc(pc), .flags(flags),
    .halted(halted), .obs_sel(obs_sel), .obs_data(obs_data)
  );

  always @(negedge clk) fetch_ack <= ($urandom % 100) < ack_pct;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] opc, input int rd,
                                      input int ra, input int rb, input int lo);
    return {opc, 3'(rd), 3'(ra), 3'(rb), 3'(lo)};
  endfunction

  function automatic logic [15:0] enc_imm(input logic [3:0] opc, input int rd,
                                          input logic [7:0] imm);
    return {opc, 3'(rd), 1'b0, imm};
  endfunction

  function automatic logic [3:0] model_flags(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    logic [15:0] d;
    s = {1'b0, a} + {1'b0, ~b} + 17'd1;
    d = s[15:0];
    return {d == 0, d[15], (a[15] != b[15]) && (d[15] != a[15]), s[16]};
  endfunction

  function automatic bit model_taken(input int code, input logic [3:0] f);
    bit z, lt;
    z  = f[3];
    lt = f[2] ^ f[1];
    case (code)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return lt;
      4: return z || lt;
      5: return !(z || lt);
      6: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) imem[i] = 16'hF000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(output int cyc);
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
      if (cyc > 4000) begin
        chk(1'b0, "R9 watchdog halt", cyc, 0);
        break;
      end
    end
  endtask

  task automatic peek(input int r, output logic [15:0] v);
    obs_sel = 3'(r);
    #0.1;
    v = obs_data;
  endtask

  task automatic cmp_trial(input logic [15:0] a, input logic [15:0] b, input int code);
    logic [15:0] v;
    logic [3:0]  ef;
    int          cyc;
    int          exp_pc;
    clear_mem();
    imem[0]  = enc_imm(4'd3, 1, a[7:0]);
    imem[1]  = enc_imm(4'd4, 1, a[15:8]);
    imem[2]  = enc_imm(4'd3, 2, b[7:0]);
    imem[3]  = enc_imm(4'd4, 2, b[15:8]);
    imem[4]  = enc(4'd5, 3, 1, 2, 0);
    imem[5]  = enc(4'd6, 4, 1, 2, 0);
    imem[6]  = enc(4'd7, 5, 1, 2, 0);
    imem[7]  = enc(4'd8, 6, 1, 2, 0);
    imem[8]  = enc(4'd1, 1, 1, 2, 0);   // rd field names r1: must stay unwritten
    imem[9]  = enc(4'd5, 7, 1, 2, 0);   // flags must survive
    imem[10] = enc(4'd2, 0, 0, 0, code);
    imem[11] = 16'd40;
    do_reset();
    run_to_halt(cyc);
    ef = model_flags(a, b);
    exp_pc = model_taken(code, ef) ? 41 : 13;
    chk(flags == ef, "R4/R5 flags after compare", flags, ef);
    chk(pc == 8'(exp_pc), "R6/R7 branch outcome pc", pc, exp_pc);
    peek(1, v); chk(v == a, "R4/R8 r1 unchanged by CMP", v, a);
    peek(2, v); chk(v == b, "R8 LDI/LHI load", v, b);
    peek(3, v); chk(v == a + b, "R8 ADD", v, a + b);
    peek(4, v); chk(v == a - b, "R8 SUB", v, a - b);
    peek(5, v); chk(v == (a & b), "R8 AND", v, a & b);
    peek(6, v); chk(v == (a | b), "R8 OR", v, a | b);
  endtask

  initial begin
    int cyc, pc_hold;
    logic [15:0] v;
    void'($urandom(32'h5EED_0042));
    clear_mem();
    // R1: reset state
    do_reset();
    chk(pc == 0, "R1 pc after reset", pc, 0);
    chk(flags == 0, "R1 flags after reset", flags, 0);
    chk(!halted, "R1 halted after reset", halted, 0);
    chk(fetch_req, "R1 fetch_req after reset", fetch_req, 1);

    // counting loop: A from 0 while A < 5, B += A
    clear_mem();
    imem[0] = enc_imm(4'd3, 1, 8'd0);
    imem[1] = enc_imm(4'd3, 2, 8'd0);
    imem[2] = enc_imm(4'd3, 3, 8'd5);
    imem[3] = enc_imm(4'd3, 4, 8'd1);
    imem[4] = enc(4'd5, 2, 2, 1, 0);
    imem[5] = enc(4'd5, 1, 1, 4, 0);
    imem[6] = enc(4'd1, 0, 1, 3, 0);
    imem[7] = enc(4'd2, 0, 0, 0, 3);
    imem[8] = 16'd4;
    imem[9] = 16'hF000;
    ack_pct = 100;
    do_reset();
    run_to_halt(cyc);
    chk(cyc == 4 * 2 + 5 * (3 * 2 + 3) + 1, "R10 loop cycle count", cyc, 54);
    chk(pc == 10, "R6 loop exit pc", pc, 10);
    chk(flags == 4'b1001, "R4 final flags Z,C", flags, 4'b1001);
    peek(1, v); chk(v == 5, "R11 A final", v, 5);
    peek(2, v); chk(v == 10, "R11 B final", v, 10);
    pc_hold = pc;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(halted && !fetch_req, "R9 stays halted, no fetch", fetch_req, 0);
    chk(pc == 8'(pc_hold), "R9 pc frozen", pc, pc_hold);

    // unknown opcode acts as NOP
    clear_mem();
    imem[0] = enc_imm(4'd3, 1, 8'h33);
    imem[1] = enc(4'd12, 1, 1, 1, 0);
    do_reset();
    run_to_halt(cyc);
    peek(1, v);
    chk(v == 16'h33 && cyc == 5, "R3 undefined opcode is NOP", v, 16'h33);

    // directed compare corners, with back-pressure
    ack_pct = 60;
    for (int c = 0; c < 8; c++) begin
      cmp_trial(16'h8000, 16'h0001, c);
      cmp_trial(16'h1234, 16'h1234, c);
      cmp_trial(16'h7FFF, 16'hFFFF, c);
      cmp_trial(16'h0001, 16'h0002, c);
    end
    // random trials
    for (int t = 0; t < 60; t++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (t % 5 == 0) ? ra : 16'($urandom);
      cmp_trial(ra, rb, int'($urandom % 8));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule